// File: doc/BRIEF.md
# Fully Associative Page Translation Buffer

This block caches recent virtual-to-physical page translations so that an address can be translated without a page-table walk. It holds 32 entries, and a translation may occupy any of them. A lookup presents a 34-bit virtual address. The upper 21 bits are compared against the tag of every valid entry at once. The 13-bit page offset bypasses translation and is rejoined with the stored 21-bit frame number to form a 34-bit physical address. Each entry also carries separate read and write permission bits. A lookup that matches an entry but is not allowed by those bits reports a protection fault instead of a hit.

Translations are loaded by an external agent, typically a software miss handler, through a fill port. A fill is placed in one of three places, in this order of preference:
- the entry that already holds the same tag, overwritten in place;
- the lowest-numbered empty entry;
- the entry named by a round-robin eviction pointer.

A flush input empties the whole buffer. Lookup is purely combinational. Fill and flush take effect at the next rising clock edge.

Top module: `xlat_buffer`

## Requirements
- R1: After synchronous reset every entry is invalid and the eviction pointer selects entry 0, so every lookup reports a miss.
- R2: When `lk_valid` is high and bits [33:13] of `lk_vaddr` equal the tag of a valid entry whose permissions allow the access, `hit` is 1 in the same cycle. In that case `paddr` equals {stored frame, `lk_vaddr[12:0]`}.
- R3: When `lk_valid` is high and no valid entry matches, `miss` is 1 and `paddr` is 0.
- R4: A matching lookup with `lk_write`=1 to an entry whose write permission is 0 raises `prot_fault` instead of `hit`. A matching lookup with `lk_write`=0 to an entry whose read permission is 0 also raises `prot_fault`. On a fault `paddr` is 0.
- R5: A fill written on one clock edge is visible to lookups from the next cycle. If an entry is invalid, the lowest-numbered invalid entry receives the fill.
- R6: With all entries valid, a fill of a new tag replaces the entry named by the eviction pointer. The pointer then advances by one, wrapping from 31 to 0, and it moves only on such evictions.
- R7: A fill whose tag is already held by a valid entry overwrites that entry's frame and permissions in place. It does not consume another entry and does not advance the pointer.
- R8: `flush_all` invalidates every entry and returns the eviction pointer to entry 0 at the next edge. It takes priority over a fill in the same cycle, which is dropped.
- R9: At most one valid entry ever matches a given tag.
- R10: `hit`, `miss` and `prot_fault` are never high together, and all three are 0 while `lk_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 34 | Virtual address: tag [33:13], offset [12:0] |
| lk_write | input | 1 | 1 = write access, 0 = read access |
| hit | output | 1 | Translation found and permitted |
| miss | output | 1 | No valid entry matches |
| prot_fault | output | 1 | Entry matches but access not permitted |
| paddr | output | 34 | Physical address {frame, offset}, 0 unless hit |
| fill_en | input | 1 | Write a translation at the next edge |
| fill_tag | input | 21 | Virtual tag to load |
| fill_frame | input | 21 | Physical frame number to load |
| fill_rd | input | 1 | Read permission of the loaded entry |
| fill_wr | input | 1 | Write permission of the loaded entry |
| flush_all | input | 1 | Invalidate every entry at the next edge |

## Verification
The bench fills all 32 entries and then evicts. A pointer that starts elsewhere or fails to wrap would remove a different translation than the one the bench checks for. It refills a tag that is already present; a design that ignores that case would leave a stale duplicate, so the old frame could still answer or the pointer would skip an entry. It issues flush and fill together and checks that the filled tag stays absent, and it checks that a flush sends the next eviction back to entry 0. Permission checks cover reads and writes separately, because a design that confused the two would hit where a fault is required.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    localparam int TAG_W   = 21;
    localparam int FRAME_W = 21;
    localparam int OFF_W   = 13;
    localparam int VA_W    = TAG_W + OFF_W;
    localparam int PA_W    = FRAME_W + OFF_W;

    typedef struct packed {
        logic               valid;
        logic               can_rd;
        logic               can_wr;
        logic [TAG_W-1:0]   tag;
        logic [FRAME_W-1:0] frame;
    } xlat_entry_t;

    typedef enum logic [1:0] {
        LK_IDLE  = 2'd0,
        LK_HIT   = 2'd1,
        LK_MISS  = 2'd2,
        LK_FAULT = 2'd3
    } lk_status_e;

    function automatic logic access_ok(input xlat_entry_t e, input logic is_write);
        return is_write ? e.can_wr : e.can_rd;
    endfunction

    function automatic logic [PA_W-1:0] join_pa(input logic [FRAME_W-1:0] frame,
                                                input logic [OFF_W-1:0] off);
        return {frame, off};
    endfunction
endpackage

// File: rtl/xlat_store.sv
module xlat_store
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_go,
    input  logic [IDX_W-1:0]          wr_idx,
    input  xlat_entry_t               wr_data,
    input  logic                      flush,
    output xlat_entry_t [ENTRIES-1:0] slots
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || flush) begin
                slots[i] <= '0;
            end else if (wr_go && wr_idx == IDX_W'(i)) begin
                slots[i] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/xlat_cam.sv
module xlat_cam
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  xlat_entry_t [ENTRIES-1:0] slots,
    input  logic [TAG_W-1:0]          key,
    output logic [ENTRIES-1:0]        match_vec,
    output xlat_entry_t               sel
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign match_vec[i] = slots[i].valid && (slots[i].tag == key);
    end

    // one-hot AND-OR multiplexer
    always_comb begin
        sel = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            sel = sel | (slots[i] & {$bits(xlat_entry_t){match_vec[i]}});
        end
    end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fill_go,
    input  logic               flush,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic [ENTRIES-1:0] same_tag,
    output logic [IDX_W-1:0]   idx,
    output logic               evict
);
    logic [IDX_W-1:0] ptr;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] dup_idx;
    logic             any_free;
    logic             any_dup;

    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                any_free = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        any_dup = 1'b0;
        dup_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (same_tag[i]) begin
                any_dup = 1'b1;
                dup_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        evict = 1'b0;
        if (any_dup) begin
            idx = dup_idx;
        end else if (any_free) begin
            idx = free_idx;
        end else begin
            idx   = ptr;
            evict = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ptr <= '0;
        end else if (fill_go && evict) begin
            ptr <= (ptr == IDX_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
        end
    end

    // R6
    ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(fill_go && evict) && !flush) |=> $stable(ptr));

    // R8
    ptr_flush_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (ptr == '0));
endmodule

// File: rtl/xlat_buffer.sv
module xlat_buffer
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32,
    localparam int IDX_W = $clog2(ENTRIES)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                lk_valid,
    input  logic [VA_W-1:0]     lk_vaddr,
    input  logic                lk_write,
    output logic                hit,
    output logic                miss,
    output logic                prot_fault,
    output logic [PA_W-1:0]     paddr,
    input  logic                fill_en,
    input  logic [TAG_W-1:0]    fill_tag,
    input  logic [FRAME_W-1:0]  fill_frame,
    input  logic                fill_rd,
    input  logic                fill_wr,
    input  logic                flush_all
);
    xlat_entry_t [ENTRIES-1:0] slots;
    logic [ENTRIES-1:0]        lk_match;
    logic [ENTRIES-1:0]        fill_match;
    logic [ENTRIES-1:0]        valid_vec;
    xlat_entry_t               lk_sel;
    xlat_entry_t               fill_sel;
    xlat_entry_t               new_entry;
    logic [IDX_W-1:0]          fill_idx;
    logic                      fill_evict;
    logic                      fill_go;
    lk_status_e                status;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_valid
        assign valid_vec[i] = slots[i].valid;
    end

    assign fill_go   = fill_en && !flush_all;
    assign new_entry = '{valid: 1'b1, can_rd: fill_rd, can_wr: fill_wr,
                         tag: fill_tag, frame: fill_frame};

    xlat_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (fill_go),
        .wr_idx  (fill_idx),
        .wr_data (new_entry),
        .flush   (flush_all),
        .slots   (slots)
    );

    xlat_cam #(.ENTRIES(ENTRIES)) u_lk_cam (
        .slots     (slots),
        .key       (lk_vaddr[VA_W-1:OFF_W]),
        .match_vec (lk_match),
        .sel       (lk_sel)
    );

    xlat_cam #(.ENTRIES(ENTRIES)) u_fill_cam (
        .slots     (slots),
        .key       (fill_tag),
        .match_vec (fill_match),
        .sel       (fill_sel)
    );

    xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .fill_go   (fill_go),
        .flush     (flush_all),
        .valid_vec (valid_vec),
        .same_tag  (fill_match),
        .idx       (fill_idx),
        .evict     (fill_evict)
    );

    always_comb begin
        if (!lk_valid) begin
            status = LK_IDLE;
        end else if (lk_match == '0) begin
            status = LK_MISS;
        end else if (access_ok(lk_sel, lk_write)) begin
            status = LK_HIT;
        end else begin
            status = LK_FAULT;
        end
    end

    assign hit        = (status == LK_HIT);
    assign miss       = (status == LK_MISS);
    assign prot_fault = (status == LK_FAULT);
    assign paddr      = hit ? join_pa(lk_sel.frame, lk_vaddr[OFF_W-1:0]) : '0;

    // R9
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(lk_match) && $onehot0(fill_match));

    // R10
    status_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({hit, miss, prot_fault}) && (lk_valid || !(hit || miss || prot_fault)));

    // R2
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (paddr[OFF_W-1:0] == lk_vaddr[OFF_W-1:0]));

    // R5
    fill_land_chk: assert property (@(posedge clk) disable iff (rst)
        fill_go |=> (slots[$past(fill_idx)].valid && slots[$past(fill_idx)].tag == $past(fill_tag)));

    // R8
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush_all |=> (valid_vec == '0));

    // R1
    reset_empty_chk: assert property (@(posedge clk)
        rst |=> (valid_vec == '0));
endmodule

// File: tb/xlat_buffer_bench.sv
module xlat_buffer_bench;
    import xlat_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               lk_valid = 1'b0;
    logic [VA_W-1:0]    lk_vaddr = '0;
    logic               lk_write = 1'b0;
    logic               hit, miss, prot_fault;
    logic [PA_W-1:0]    paddr;
    logic               fill_en = 1'b0;
    logic [TAG_W-1:0]   fill_tag = '0;
    logic [FRAME_W-1:0] fill_frame = '0;
    logic               fill_rd = 1'b0;
    logic               fill_wr = 1'b0;
    logic               flush_all = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xlat_buffer u_xlat_buffer (
        .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
        .lk_write(lk_write), .hit(hit), .miss(miss), .prot_fault(prot_fault),
        .paddr(paddr), .fill_en(fill_en), .fill_tag(fill_tag),
        .fill_frame(fill_frame), .fill_rd(fill_rd), .fill_wr(fill_wr),
        .flush_all(flush_all)
    );

    // expected status codes: 1 hit, 2 miss, 4 fault
    localparam logic [2:0] E_HIT = 3'b001, E_MISS = 3'b010, E_FLT = 3'b100;

    typedef struct packed {
        logic               is_fill;
        logic [TAG_W-1:0]   tag;
        logic [FRAME_W-1:0] frame;
        logic               rd;
        logic               wr;
        logic               wacc;
        logic [OFF_W-1:0]   off;
        logic [2:0]         expect_st;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 21'h00100, 21'h0,      1'b0, 1'b0, 1'b0, 13'h00AB, E_MISS},
        '{1'b1, 21'h00100, 21'h1ABCD,  1'b1, 1'b0, 1'b0, 13'h0,    3'b000},
        '{1'b0, 21'h00100, 21'h1ABCD,  1'b0, 1'b0, 1'b0, 13'h00AB, E_HIT},
        '{1'b0, 21'h00100, 21'h1ABCD,  1'b0, 1'b0, 1'b1, 13'h00AB, E_FLT},
        '{1'b1, 21'h1FFFFF, 21'h00042, 1'b1, 1'b1, 1'b0, 13'h0,    3'b000},
        '{1'b0, 21'h1FFFFF, 21'h00042, 1'b0, 1'b0, 1'b1, 13'h1FFF, E_HIT},
        '{1'b1, 21'h00007, 21'h12345,  1'b0, 1'b1, 1'b0, 13'h0,    3'b000},
        '{1'b0, 21'h00007, 21'h12345,  1'b0, 1'b0, 1'b0, 13'h0042, E_FLT},
        '{1'b0, 21'h00007, 21'h12345,  1'b0, 1'b0, 1'b1, 13'h0000, E_HIT},
        '{1'b0, 21'h00101, 21'h0,      1'b0, 1'b0, 1'b0, 13'h0011, E_MISS}
    };

    task automatic do_fill(input logic [TAG_W-1:0] t, input logic [FRAME_W-1:0] f,
                           input logic r, input logic w, input logic fl);
        @(negedge clk);
        fill_en = 1'b1; fill_tag = t; fill_frame = f; fill_rd = r; fill_wr = w;
        flush_all = fl;
        @(negedge clk);
        fill_en = 1'b0; flush_all = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_all = 1'b1;
        @(negedge clk);
        flush_all = 1'b0;
    endtask

    task automatic look(input string req, input logic [TAG_W-1:0] t,
                        input logic [OFF_W-1:0] off, input logic w,
                        input logic [2:0] exp_st, input logic [FRAME_W-1:0] exp_fr);
        logic [PA_W-1:0] exp_pa;
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = {t, off}; lk_write = w;
        #2;
        exp_pa = (exp_st == E_HIT) ? {exp_fr, off} : '0;
        n_run++;
        if ({prot_fault, miss, hit} !== exp_st || paddr !== exp_pa) begin
            n_fail++;
            $display("FAIL %s tag=%h status=%b/%b paddr=%h/%h (actual/expected)",
                     req, t, {prot_fault, miss, hit}, exp_st, paddr, exp_pa);
        end
        lk_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state, R2/R3/R4/R5 through the vector table
        foreach (VECS[i]) begin
            if (VECS[i].is_fill)
                do_fill(VECS[i].tag, VECS[i].frame, VECS[i].rd, VECS[i].wr, 1'b0);
            else
                look("R1-table", VECS[i].tag, VECS[i].off, VECS[i].wacc,
                     VECS[i].expect_st, VECS[i].frame);
        end

        // R8 flush empties the buffer
        do_flush();
        look("R8 flush", 21'h00100, 13'h1, 1'b0, E_MISS, 21'h0);
        look("R8 flush", 21'h1FFFFF, 13'h1, 1'b1, E_MISS, 21'h0);

        // R5 fill all 32 entries
        for (int i = 0; i < 32; i++) do_fill(21'h1000 + 21'(i), 21'h2000 + 21'(i), 1'b1, 1'b1, 1'b0);
        for (int i = 0; i < 32; i++) look("R5 full", 21'h1000 + 21'(i), 13'(i * 7), 1'(i % 2), E_HIT, 21'h2000 + 21'(i));

        // R6 eviction starts at entry 0 then entry 1
        do_fill(21'h0500, 21'h0AAA, 1'b1, 1'b1, 1'b0);
        look("R6 evict0", 21'h1000, 13'h0, 1'b0, E_MISS, 21'h0);
        look("R6 new", 21'h0500, 13'h123, 1'b0, E_HIT, 21'h0AAA);
        look("R6 keep1", 21'h1001, 13'h0, 1'b0, E_HIT, 21'h2001);
        do_fill(21'h0501, 21'h0BBB, 1'b1, 1'b1, 1'b0);
        look("R6 evict1", 21'h1001, 13'h0, 1'b0, E_MISS, 21'h0);

        // R7 same-tag refill overwrites in place, pointer stays at 2
        do_fill(21'h1005, 21'h3333, 1'b1, 1'b0, 1'b0);
        look("R7 frame", 21'h1005, 13'h55, 1'b0, E_HIT, 21'h3333);
        look("R7 perm", 21'h1005, 13'h55, 1'b1, E_FLT, 21'h0);
        do_fill(21'h0502, 21'h0CCC, 1'b1, 1'b1, 1'b0);
        look("R7 ptr", 21'h1002, 13'h0, 1'b0, E_MISS, 21'h0);
        look("R7 ptr", 21'h1003, 13'h0, 1'b0, E_HIT, 21'h2003);

        // R8 flush beats a simultaneous fill and resets the pointer
        do_fill(21'h0777, 21'h0DDD, 1'b1, 1'b1, 1'b1);
        look("R8 prio", 21'h0777, 13'h0, 1'b0, E_MISS, 21'h0);
        look("R8 prio", 21'h1003, 13'h0, 1'b0, E_MISS, 21'h0);
        for (int i = 0; i < 32; i++) do_fill(21'h1000 + 21'(i), 21'h2000 + 21'(i), 1'b1, 1'b1, 1'b0);
        do_fill(21'h0600, 21'h0EEE, 1'b1, 1'b1, 1'b0);
        look("R8 ptr0", 21'h1000, 13'h0, 1'b0, E_MISS, 21'h0);
        look("R8 ptr0", 21'h1003, 13'h0, 1'b0, E_HIT, 21'h2003);

        // R10 idle lookup drives nothing
        @(negedge clk);
        lk_valid = 1'b0; lk_vaddr = {21'h1003, 13'h0}; lk_write = 1'b0;
        #2;
        n_run++;
        if ({prot_fault, miss, hit} !== 3'b000 || paddr !== '0) begin
            n_fail++;
            $display("FAIL R10 idle status=%b paddr=%h expected 000/0", {prot_fault, miss, hit}, paddr);
        end

        // R9 one match only: refilled tag never returns the old frame
        do_fill(21'h1004, 21'h3444, 1'b1, 1'b1, 1'b0);
        look("R9 unique", 21'h1004, 13'h9, 1'b0, E_HIT, 21'h3444);

        // R1 reset clears all entries
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        look("R1 reset", 21'h1004, 13'h0, 1'b0, E_MISS, 21'h0);
        look("R1 reset", 21'h0600, 13'h0, 1'b0, E_MISS, 21'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule